// File: doc/BRIEF.md
# Vector Playback Address Sequencer

This block drives the address of a vector store during test-pattern playback. When a start pulse arrives while it is not running, it starts at address zero. It then issues one vector address per vector cycle and counts up to a programmed end address. At the end address it either halts and raises a done flag, or jumps back to a programmed loop address when the loop-enable input is high. The loop address, the end address and a control word are written over a simple register-write bus. The live address is always visible on its own output.

In normal mode the sequencer issues a read strobe with the address. The vector store returns its 40-bit word one cycle later, and the block presents that word with a valid strobe. When the bypass bit of the control word is set, the store is not read. Instead, software stages four 10-bit words in holding registers. Each write to the last of the four counts as one vector: the block presents the four staged words as a vector and advances the address by one.

Top module: `vec_addr_seq`

## Requirements
- R1: After reset the address output is 0, done, ram_rd and vec_valid are low, and the loop and end registers hold 0, so a start with no writes issues address 0 only and then sets done.
- R2: A start pulse while idle or done moves the sequencer to running with address 0. In each running cycle in normal mode, ram_rd is high and ram_addr equals the current address.
- R3: While running, the address increases by exactly one per vector cycle as long as it differs from the end address.
- R4: When the end address is issued and loop_en is low, the sequencer stops. The address stays at the end value, ram_rd falls, and done rises and stays high until the next start.
- R5: When the end address is issued and loop_en is high, the next address equals the loop address and running continues.
- R6: A start pulse while running has no effect on the address. A start pulse while done clears done and restarts from address 0.
- R7: vec_valid is high in the cycle after each normal-mode read strobe, and vec_data then equals ram_rdata.
- R8: With the bypass bit set, ram_rd stays low. The address advances only on a write to staging word 3. In the next cycle vec_valid is high and vec_data is {word3, word2, word1, word0}, with word0 in bits 9:0.
- R9: bus_sel selects the register for a write: 0 is the loop address, 1 is the end address, 2 is the control word with the bypass bit at bit 9, and 4 to 7 are staging words 0 to 3.
- R10: A write to the end register takes effect in the cycle after the write edge. A comparison made on the same edge uses the previous end value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin playback from address 0 |
| loop_en | input | 1 | At the end address, wrap to the loop address instead of stopping |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 3 | Register select for the write |
| bus_wdata | input | 10 | Register write data |
| cur_addr | output | 10 | Current vector address |
| ram_rd | output | 1 | Vector store read strobe |
| ram_addr | output | 10 | Vector store address |
| ram_rdata | input | 40 | Vector store data, valid the cycle after ram_rd |
| vec_valid | output | 1 | Vector output valid |
| vec_data | output | 40 | Vector output (four 10-bit words) |
| done | output | 1 | Playback halted at the end address |

## Verification
The end-address comparison and a write to the end register can fall on the same clock edge. The bench provokes this by running a short pattern with end address 3 and writing a larger end value exactly on the edge where address 3 is issued. It judges the result by requiring done to be high with the address held at 3, because the old end value must win.

// File: rtl/vec_addr_seq.sv
module vec_addr_seq #(
  parameter int AW = 10,
  parameter int WW = 10,
  parameter int NW = 4,
  parameter int SW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             loop_en,
  input  logic             bus_wr,
  input  logic [SW-1:0]    bus_sel,
  input  logic [WW-1:0]    bus_wdata,
  output logic [AW-1:0]    cur_addr,
  output logic             ram_rd,
  output logic [AW-1:0]    ram_addr,
  input  logic [NW*WW-1:0] ram_rdata,
  output logic             vec_valid,
  output logic [NW*WW-1:0] vec_data,
  output logic             done
);
  localparam logic [SW-1:0] SEL_LOOP  = SW'(0);
  localparam logic [SW-1:0] SEL_END   = SW'(1);
  localparam logic [SW-1:0] SEL_CTL   = SW'(2);
  localparam int            WORD_BASE = 4;
  localparam logic [SW-1:0] SEL_LAST  = SW'(WORD_BASE + NW - 1);
  localparam int            BYP_BIT   = WW - 1;
  localparam int            VW        = NW * WW;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  st_t                     st_q;
  logic [AW-1:0]           cur_q, loop_q, end_q;
  logic [WW-1:0]           ctl_q;
  logic [NW-1:0][WW-1:0]   stage_q;
  logic [VW-1:0]           snap_q, snap_d;
  logic                    valid_q, from_stage_q;

  wire running  = (st_q == S_RUN);
  wire byp      = ctl_q[BYP_BIT];
  wire last_wr  = bus_wr && (bus_sel == SEL_LAST);
  wire step_byp = running && byp && last_wr;
  wire at_end   = (cur_q == end_q);

  assign ram_rd    = running && !byp;
  assign ram_addr  = cur_q;
  assign cur_addr  = cur_q;
  assign done      = (st_q == S_DONE);
  assign vec_valid = valid_q;
  assign vec_data  = from_stage_q ? snap_q : ram_rdata;

  wire advance = ram_rd || step_byp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= '0;
      end_q  <= '0;
      ctl_q  <= '0;
    end else if (bus_wr) begin
      case (bus_sel)
        SEL_LOOP: loop_q <= bus_wdata[AW-1:0];
        SEL_END:  end_q  <= bus_wdata[AW-1:0];
        SEL_CTL:  ctl_q  <= bus_wdata;
        default:  ;
      endcase
    end
  end

  for (genvar i = 0; i < NW; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage_q[i] <= '0;
      else if (bus_wr && bus_sel == SW'(WORD_BASE + i))
        stage_q[i] <= bus_wdata;
    end
    if (i == NW - 1) begin : g_top
      assign snap_d[i*WW +: WW] = bus_wdata;
    end else begin : g_low
      assign snap_d[i*WW +: WW] = stage_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cur_q <= '0;
    end else if (start && !running) begin
      st_q  <= S_RUN;
      cur_q <= '0;
    end else if (advance) begin
      if (!at_end)
        cur_q <= cur_q + AW'(1);
      else if (loop_en)
        cur_q <= loop_q;
      else
        st_q <= S_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q      <= 1'b0;
      from_stage_q <= 1'b0;
      snap_q       <= '0;
    end else begin
      valid_q      <= advance;
      from_stage_q <= step_byp;
      if (step_byp) snap_q <= snap_d;
    end
  end

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd && !start && cur_addr != end_q) |=> (cur_addr == $past(cur_addr) + AW'(1)));

  // R5
  wrap_to_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd && cur_addr == end_q && loop_en) |=> (cur_addr == $past(loop_q)));

  // R4
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !ram_rd && $stable(cur_addr)));

  // R7
  rd_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |=> vec_valid);

  // R8
  byp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_rd && !last_wr && !start) |=> $stable(cur_addr));
endmodule

// File: tb/vec_addr_seq_tb_top.sv
module vec_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        loop_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic [9:0]  bus_wdata = '0;
  logic [9:0]  cur_addr, ram_addr;
  logic        ram_rd, vec_valid, done;
  logic [39:0] ram_rdata = '0;
  logic [39:0] vec_data;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vec_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .loop_en(loop_en),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .cur_addr(cur_addr), .ram_rd(ram_rd), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .vec_valid(vec_valid), .vec_data(vec_data),
    .done(done)
  );

  function automatic logic [39:0] pat(input logic [9:0] a);
    return {a ^ 10'h3FF, a ^ 10'h155, a ^ 10'h0AA, a};
  endfunction

  always_ff @(posedge clk) if (ram_rd) ram_rdata <= pat(ram_addr);

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; loop_en = 1'b0; bus_wr = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int sel, input int data);
    bus_wr = 1'b1; bus_sel = 3'(sel); bus_wdata = 10'(data);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // columns: end, loop, loop_en, edges after start, expected address, expected done
  localparam int ROWS = 5;
  localparam int TBL [ROWS][6] = '{
    '{3, 0, 0,  8, 3, 1},
    '{2, 1, 1,  6, 2, 0},
    '{0, 0, 0,  4, 0, 1},
    '{5, 3, 1, 10, 4, 0},
    '{3, 2, 0,  5, 3, 1}
  };

  initial begin
    #2ms;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 addr", cur_addr, 0);
    check("R1 done", done, 0);
    check("R1 ram_rd", ram_rd, 0);
    check("R1 vec_valid", vec_valid, 0);
    // R1 cleared end register: start issues address 0 then stops
    pulse_start();
    check("R2 rd", ram_rd, 1);
    check("R2 addr", ram_addr, 0);
    @(negedge clk);
    // R7 vector follows read by one cycle
    check("R7 valid", vec_valid, 1);
    check("R7 data", vec_data, pat(10'd0));
    check("R1 done", done, 1);
    check("R1 addr", cur_addr, 0);

    // table walk: R3 R4 R5
    for (int r = 0; r < ROWS; r++) begin
      do_reset();
      wr(1, TBL[r][0]);
      wr(0, TBL[r][1]);
      loop_en = TBL[r][2][0];
      pulse_start();
      repeat (TBL[r][3]) @(negedge clk);
      check(TBL[r][2] != 0 ? "R5 addr" : "R3/R4 addr", cur_addr, TBL[r][4]);
      check("R4 done", done, TBL[r][5]);
      if (TBL[r][5] != 0) check("R4 rd low", ram_rd, 0);
    end

    // R6 start while running ignored; restart from done
    do_reset();
    wr(1, 10);
    pulse_start();
    repeat (3) @(negedge clk);
    check("R3 addr", cur_addr, 3);
    pulse_start();
    check("R6 running start", cur_addr, 4);
    repeat (8) @(negedge clk);
    check("R4 done", done, 1);
    check("R4 addr", cur_addr, 10);
    pulse_start();
    check("R6 done clear", done, 0);
    check("R6 restart", cur_addr, 0);

    // R10 end write on the same edge as the end comparison
    do_reset();
    wr(1, 3);
    pulse_start();
    repeat (3) @(negedge clk);
    wr(1, 8);
    check("R10 done", done, 1);
    check("R10 addr", cur_addr, 3);

    // R8 R9 bypass
    do_reset();
    wr(2, 10'h200);
    wr(1, 20);
    pulse_start();
    repeat (3) @(negedge clk);
    check("R8 rd low", ram_rd, 0);
    check("R8 hold", cur_addr, 0);
    for (int s = 0; s < 4; s++) begin
      wr(4, 16 * s + 1);
      wr(5, 16 * s + 2);
      wr(6, 16 * s + 3);
      check("R8 no step", vec_valid, 0);
      wr(7, 16 * s + 4);
      check("R8 valid", vec_valid, 1);
      check("R8 data", vec_data,
            {10'(16 * s + 4), 10'(16 * s + 3), 10'(16 * s + 2), 10'(16 * s + 1)});
      check("R8 addr", cur_addr, s + 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule